// File: doc/BRIEF.md
# Embedded Message Length Extractor

This block sits beside the receive path of a host-to-device endpoint while a DMA transfer is running. It counts the bytes of the incoming data from the first packet of a message onward. It takes the two bytes that hold the message length at a programmable byte offset. The low byte sits at the offset and the high byte at offset+1. Each captured byte is placed in the upper half of a 32-bit buffer-length word.

The byte counter keeps running across packet boundaries. An offset beyond the first packet works the same way as one inside it, and so does a length whose two bytes fall in different packets. Each half of the length has its own done flag. When both are set, the block stops looking at the stream until the next descriptor-load pulse. That pulse starts a new message by clearing the flags, the captured bytes, the counter and the arming state. When the endpoint direction is device-to-host, the block does nothing.

Top module: `msg_len_extract`

## Requirements
- R1: After reset, `msgLenWord` is zero and `loDone`, `hiDone` and `extractDone` are low.
- R2: Byte counting for a message begins with the first valid byte marked by `pktStart` after reset or after a `descLoad` pulse. That byte is position 0. Valid bytes that arrive before it are ignored.
- R3: The byte at position `offset` is captured into `msgLenWord[23:16]`. `loDone` goes high on the clock edge that accepts it, so it is visible one cycle after the byte is presented.
- R4: The byte at position `offset`+1 is captured into `msgLenWord[31:24]`, and `hiDone` goes high on that same edge.
- R5: A `pktStart` marker after the first one does not reset the position. Positions keep counting across packets, so the offset may point into any later packet, and the two length bytes may sit in two different packets.
- R6: `extractDone` equals `loDone` AND `hiDone`. Once it is high, later bytes change neither the captured bytes nor the flags.
- R7: While `isOut` is low, presented bytes are ignored and the position does not advance.
- R8: A `descLoad` pulse clears `msgLenWord`, both flags, the position and the arming state on the next edge. A byte presented in the same cycle as the pulse is ignored.
- R9: Cycles with `byteValid` low do not advance the position and capture nothing.
- R10: `msgLenWord[15:0]` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| descLoad | input | 1 | New descriptor loaded; starts a fresh message |
| isOut | input | 1 | 1 = host-to-device endpoint, 0 = device-to-host |
| offset | input | OFS_W | Byte position of the length low byte |
| byteValid | input | 1 | A data byte is presented this cycle |
| pktStart | input | 1 | The presented byte is the first of a packet |
| byteData | input | 8 | Data byte |
| msgLenWord | output | 32 | Bits 31:24 high length byte, 23:16 low length byte, 15:0 zero |
| loDone | output | 1 | Low length byte captured |
| hiDone | output | 1 | High length byte captured |
| extractDone | output | 1 | Both length bytes captured |

## Verification
The hardest case to produce from the ports is a length field that lies on a packet seam, where the low byte is the last byte of one packet and the high byte the first of the next. It is hard because it depends on both the offset and the packet size. The stimulus sweeps every offset value and ties the packet size to the offset in a short repeating cycle, so the length lands before, across and after packet seams many times. Idle cycles, bytes sent while the direction is device-to-host, and bytes sent before the first packet marker are mixed into these streams. Any of them that were wrongly counted would shift the captured values.

// File: rtl/mlx_pkg.sv
package mlx_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic clear;
    logic takeLo;
    logic takeHi;
  } mlxStrb_t;
endpackage

// File: rtl/mlx_ctrl.sv
module mlx_ctrl
  import mlx_pkg::*;
#(
  parameter int OFS_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             descLoad,
  input  logic             isOut,
  input  logic [OFS_W-1:0] offset,
  input  logic             byteValid,
  input  logic             pktStart,
  output mlxStrb_t         strb,
  output logic             loDone,
  output logic             hiDone
);
  localparam int CNT_W = OFS_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] pos;
  logic             armed;
  logic             accept;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] loPos;
  logic [CNT_W-1:0] hiPos;

  assign loPos = CNT_W'(offset);
  assign hiPos = CNT_W'(offset) + CNT_W'(1);

  // a byte counts only once armed (or when it arms), on an OUT endpoint, before done
  assign accept = byteValid && isOut && !descLoad && !(loDone && hiDone)
                  && (armed || pktStart);
  assign idx    = armed ? pos : '0;

  always_comb begin
    strb.clear  = descLoad;
    strb.takeLo = accept && !loDone && (idx == loPos);
    strb.takeHi = accept && !hiDone && (idx == hiPos);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos    <= '0;
      armed  <= 1'b0;
      loDone <= 1'b0;
      hiDone <= 1'b0;
    end else if (descLoad) begin
      pos    <= '0;
      armed  <= 1'b0;
      loDone <= 1'b0;
      hiDone <= 1'b0;
    end else begin
      if (accept) begin
        armed <= 1'b1;
        pos   <= (idx == CNT_MAX) ? CNT_MAX : idx + CNT_W'(1);
      end
      if (strb.takeLo) loDone <= 1'b1;
      if (strb.takeHi) hiDone <= 1'b1;
    end
  end

  // R4: the high byte sits after the low byte, so it can never finish first
  a_r4_hi_after_lo: assert property (@(posedge clk) disable iff (!rstN)
    hiDone |-> loDone);

  // R8: descriptor load wipes the message state
  a_r8_load_clears: assert property (@(posedge clk) disable iff (!rstN)
    descLoad |=> (!loDone && !hiDone && !armed && pos == '0));

  // R7: IN direction leaves the state untouched
  a_r7_in_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!isOut && !descLoad) |=> ($stable(pos) && $stable(loDone) && $stable(hiDone)));

  // R9: no valid byte, no movement
  a_r9_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    (!byteValid && !descLoad) |=> ($stable(pos) && $stable(armed)));

  // R6: once complete, the counter and flags freeze until the next load
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (loDone && hiDone && !descLoad) |=> ($stable(pos) && loDone && hiDone));
endmodule

// File: rtl/mlx_dpath.sv
module mlx_dpath
  import mlx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  mlxStrb_t   strb,
  input  logic [7:0] byteData,
  output logic [7:0] lenLo,
  output logic [7:0] lenHi
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenLo <= '0;
      lenHi <= '0;
    end else if (strb.clear) begin
      lenLo <= '0;
      lenHi <= '0;
    end else begin
      if (strb.takeLo) lenLo <= byteData;
      if (strb.takeHi) lenHi <= byteData;
    end
  end

  // R3: the captured low byte is the byte presented on the capture cycle
  a_r3_lo_capture: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeLo && !strb.clear) |=> (lenLo == $past(byteData)));

  // R4: same for the high byte
  a_r4_hi_capture: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeHi && !strb.clear) |=> (lenHi == $past(byteData)));

  // R6: without a capture or clear strobe the bytes hold
  a_r6_lo_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.takeLo && !strb.clear) |=> $stable(lenLo));
  a_r6_hi_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.takeHi && !strb.clear) |=> $stable(lenHi));
endmodule

// File: rtl/msg_len_extract.sv
module msg_len_extract
  import mlx_pkg::*;
#(
  parameter int OFS_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             descLoad,
  input  logic             isOut,
  input  logic [OFS_W-1:0] offset,
  input  logic             byteValid,
  input  logic             pktStart,
  input  logic [7:0]       byteData,
  output logic [31:0]      msgLenWord,
  output logic             loDone,
  output logic             hiDone,
  output logic             extractDone
);
  mlxStrb_t   strb;
  logic [7:0] lenLo;
  logic [7:0] lenHi;

  mlx_ctrl #(.OFS_W(OFS_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .descLoad  (descLoad),
    .isOut     (isOut),
    .offset    (offset),
    .byteValid (byteValid),
    .pktStart  (pktStart),
    .strb      (strb),
    .loDone    (loDone),
    .hiDone    (hiDone)
  );

  mlx_dpath uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .byteData (byteData),
    .lenLo    (lenLo),
    .lenHi    (lenHi)
  );

  assign msgLenWord  = {lenHi, lenLo, 16'h0000};
  assign extractDone = loDone && hiDone;

  // R6: no capture strobe reaches the datapath after completion
  a_r6_no_late_capture: assert property (@(posedge clk) disable iff (!rstN)
    extractDone |-> !(strb.takeLo || strb.takeHi));
endmodule

// File: tb/msg_len_extract_test.sv
module msg_len_extract_test;
  localparam int OFS_W = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             descLoad = 1'b0;
  logic             isOut = 1'b1;
  logic [OFS_W-1:0] offset = '0;
  logic             byteValid = 1'b0;
  logic             pktStart = 1'b0;
  logic [7:0]       byteData = '0;
  logic [31:0]      msgLenWord;
  logic             loDone, hiDone, extractDone;

  int nRun = 0;
  int nFail = 0;

  msg_len_extract #(.OFS_W(OFS_W)) uut (
    .clk(clk), .rstN(rstN), .descLoad(descLoad), .isOut(isOut),
    .offset(offset), .byteValid(byteValid), .pktStart(pktStart),
    .byteData(byteData), .msgLenWord(msgLenWord), .loDone(loDone),
    .hiDone(hiDone), .extractDone(extractDone)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(int o, int i);
    return 8'((i * 37 + o * 11 + 5) & 255);
  endfunction

  // expected {word, loDone, hiDone, extractDone} after n accepted bytes
  function automatic logic [34:0] expState(int o, int n);
    logic lo, hi;
    lo = (n > o);
    hi = (n > o + 1);
    return {hi ? pat(o, o + 1) : 8'h00, lo ? pat(o, o) : 8'h00, 16'h0000,
            lo, hi, lo && hi};
  endfunction

  function automatic logic [34:0] gotState();
    return {msgLenWord, loDone, hiDone, extractDone};
  endfunction

  task automatic check(string req, logic [34:0] got, logic [34:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive at negedge, wait one cycle, outputs then reflect the edge
  task automatic step(logic ld, logic out, logic vld, logic st, logic [7:0] d);
    descLoad = ld; isOut = out; byteValid = vld; pktStart = st; byteData = d;
    @(negedge clk);
    descLoad = 1'b0; byteValid = 1'b0; pktStart = 1'b0; isOut = 1'b1;
  endtask

  task automatic runOffset(int o);
    int psz;
    psz = 3 + (o % 6);
    offset = OFS_W'(o);
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R8", gotState(), expState(o, 0));
    if (o % 4 == 1) begin
      // bytes before the first packet marker do not count
      step(1'b0, 1'b1, 1'b1, 1'b0, ~pat(o, 0));
      step(1'b0, 1'b1, 1'b1, 1'b0, ~pat(o, 1));
      check("R2", gotState(), expState(o, 0));
    end
    for (int k = 0; k <= o + 4; k++) begin
      if (k % 3 == 2) begin
        step(1'b0, 1'b1, 1'b0, 1'b1, ~pat(o, k));
        check("R9", gotState(), expState(o, k));
      end
      if (o % 5 == 2 && k == o) begin
        step(1'b0, 1'b0, 1'b1, (k % psz) == 0, ~pat(o, k));
        check("R7", gotState(), expState(o, k));
      end
      step(1'b0, 1'b1, 1'b1, (k % psz) == 0, pat(o, k));
      if (k == o)
        check("R3", gotState(), expState(o, k + 1));
      else if (k == o + 1)
        check((o / psz != (o + 1) / psz || o >= psz) ? "R5" : "R4",
              gotState(), expState(o, k + 1));
      else if (k > o + 1)
        check("R6", gotState(), expState(o, k + 1));
      else
        check("R5", gotState(), expState(o, k + 1));
    end
    check("R10", {19'h0, msgLenWord[15:0]}, 35'h0);
  endtask

  initial begin
    #200000;
    nRun++;
    nFail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", gotState(), 35'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", gotState(), 35'h0);

    for (int o = 0; o < (1 << OFS_W); o++) runOffset(o);

    // load coinciding with a byte: the byte is dropped
    offset = '0;
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h5A);
    check("R8", gotState(), 35'h0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'h77);
    check("R2", gotState(), 35'h0);
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h12);
    check("R3", gotState(), {8'h00, 8'h12, 16'h0, 1'b1, 1'b0, 1'b0});
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'h34);
    check("R4", gotState(), {8'h34, 8'h12, 16'h0, 1'b1, 1'b1, 1'b1});
    // load in the middle of a message restarts it
    offset = OFS_W'(1);
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'hA1);
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R8", gotState(), 35'h0);
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'hB0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'hB1);
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'hB2);
    check("R5", gotState(), {8'hB2, 8'hB1, 16'h0, 1'b1, 1'b1, 1'b1});

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule